// File: doc/BRIEF.md
# Fractional Baud Clock Generator

This block produces the bit-rate clock enables for a USART-style serial port. A 12-bit period value and a signed 4-bit scale value set a base generator tick. A positive scale multiplies the divide period by a power of two. A negative scale treats the period value as a fixed-point number and spreads its fractional part over successive ticks, which gives a finer average rate. Any write of a new period or scale value restarts the divider, so the next tick lands one full new period later.

A mode input chooses how the generator tick is used. In the two asynchronous modes the receive enable pulses on every generator tick, as an oversampling strobe, and the transmit enable pulses on every 16th tick (normal speed) or every 8th tick (double speed). In the synchronous master and SPI master modes the block drives a transfer clock pin that toggles once per generator tick. In synchronous slave mode the divider is bypassed: the external transfer clock passes through a two-stage synchroniser and an edge detector. A polarity control inverts the transfer clock. The block has no data path, so it has no valid/ready interface; every pin is plain control or strobe.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is held and on the first cycle after it is released, tx_tick and rx_tick are 0 and xck_out equals xck_inv.
- R2: For scale_val S from 0 to 7, generator ticks (rx_tick in mode 0) are spaced exactly (per_val+1)*2^S clock cycles apart.
- R3: For scale_val S from -1 to -7 with k=-S, let I=per_val>>k and F=per_val mod 2^k. Each generator period lasts I+1+c cycles, where c is the carry out of bit k of a k-bit phase accumulator. The accumulator starts at 0 and adds F at each tick. The carry from the add at one tick extends the period that follows that tick, so the first period is I+1.
- R4: A change of per_val or scale_val restarts the divider and the accumulator. The first rx_tick in mode 0 then appears P+1 rising edges after the change, counting the edge that captures the new value, where P is the first period from R2 or R3. No tick comes from that capturing edge.
- R5: Mode encodings are 0 = asynchronous normal, 1 = asynchronous double speed, 2 = synchronous master, 3 = synchronous slave and 4 = SPI master; 5 to 7 act as 0. In modes 0 and 1, rx_tick pulses on every generator tick. After a restart, tx_tick pulses together with every 16th rx_tick in mode 0 and every 8th in mode 1, and never without rx_tick.
- R6: xck_oe is 1 in modes 2 and 4 and 0 otherwise. When it is 0, xck_out rests at xck_inv.
- R7: In mode 2, xck_out toggles once per generator tick. Let e be xck_out XOR xck_inv. rx_tick pulses in the cycle where e rises and tx_tick in the cycle where e falls. Both pulse in the same cycle as the pin change, and no tick occurs without a pin change.
- R8: In mode 4, xck_out toggles once per generator tick as in R7, but the edges swap: tx_tick pulses when e rises and rx_tick when e falls. rx_tick and tx_tick never pulse together in modes 2, 3 or 4.
- R9: In mode 3, with e = xck_in XOR xck_inv, rx_tick pulses for one cycle on each rise of e and tx_tick on each fall. The pulse appears on the third rising edge after the pin change.
- R10: per_val accepts the full range 0 to 4095. With scale 0, a value of 0 gives a tick on every cycle and 4095 gives one every 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| per_val | input | 12 | Divider period value |
| scale_val | input | 4 | Signed scale, -7 to +7 |
| mode | input | 3 | Clock mode select (encoding in R5) |
| xck_inv | input | 1 | Transfer clock polarity invert |
| xck_in | input | 1 | External transfer clock (slave mode) |
| tx_tick | output | 1 | Transmit clock enable, one cycle |
| rx_tick | output | 1 | Receive clock enable, one cycle |
| xck_out | output | 1 | Transfer clock output level |
| xck_oe | output | 1 | Transfer clock output enable |

## Verification
In the asynchronous modes the transmit enable and the oversampling receive enable fall in the same cycle on every 16th (or 8th) generator tick. The bench restarts the divider with a known period, counts receive pulses, and requires tx_tick exactly on the multiples while rx_tick stays high in that cycle. The second collision is a configuration write that lands on the cycle a tick was due. The bench sweeps every period and scale pair of a small grid back to back, and each new pair must suppress the old tick and deliver its first tick exactly P+1 edges later.

// File: rtl/frac_baud_pkg.sv
`timescale 1ns/1ps
package frac_baud_pkg;
  typedef enum logic [2:0] {
    CLK_ASYNC    = 3'd0,
    CLK_ASYNC_2X = 3'd1,
    CLK_SYNC_MST = 3'd2,
    CLK_SYNC_SLV = 3'd3,
    CLK_SPI_MST  = 3'd4
  } clk_mode_e;
endpackage

// File: rtl/baud_period_gen.sv
`timescale 1ns/1ps
// Base tick divider: power-of-two stretch for positive scale,
// phase-accumulator dithering for negative scale.
module baud_period_gen #(
  parameter int PER_W = 12,
  parameter int SCL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PER_W-1:0]        per,
  input  logic signed [SCL_W-1:0] scale,
  output logic                    gen_tick,
  output logic                    restart
);
  localparam int MAX_SH = (1 << (SCL_W - 1)) - 1;
  localparam int CNT_W  = PER_W + MAX_SH + 1;
  localparam int ACC_W  = MAX_SH;
  localparam int CFG_W  = PER_W + SCL_W;

  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] frac;
  logic [ACC_W-1:0] frac_mask;
  logic [ACC_W-1:0] acc_nxt;
  logic [ACC_W:0]   sum;
  logic [SCL_W-1:0] mag;
  logic             neg;
  logic             extra;
  logic             carry;

  assign restart = ({per, scale} != cfg_q);

  always_comb begin
    neg = scale[SCL_W-1];
    mag = neg ? SCL_W'(-scale) : SCL_W'(scale);
    if (mag > SCL_W'(MAX_SH)) mag = SCL_W'(MAX_SH);
    frac_mask = ACC_W'((1 << mag) - 1);
    frac      = per[ACC_W-1:0] & frac_mask;
    sum       = {1'b0, acc} + {1'b0, frac};
    carry     = ((sum >> mag) != '0);
    acc_nxt   = sum[ACC_W-1:0] & frac_mask;
    if (neg) limit = CNT_W'(per >> mag) + CNT_W'(extra);
    else     limit = ((CNT_W'(per) + CNT_W'(1)) << mag) - CNT_W'(1);
  end

  assign gen_tick = (cnt == limit) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt   <= '0;
      acc   <= '0;
      extra <= 1'b0;
    end else begin
      cfg_q <= {per, scale};
      if (restart) begin
        cnt   <= '0;
        acc   <= '0;
        extra <= 1'b0;
      end else if (gen_tick) begin
        cnt <= '0;
        if (neg) begin
          acc   <= acc_nxt;
          extra <= carry;
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/xck_sync_edge.sv
`timescale 1ns/1ps
// Synchroniser chain plus edge detector for the external transfer clock.
module xck_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) sync_q[i] <= sync_q[i-1];
      sync_q[0] <= pin;
      last_q    <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
  assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/tick_router.sv
`timescale 1ns/1ps
// Turns the base tick into per-mode transmit/receive enables and clock level.
module tick_router
  import frac_baud_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       inv,
  input  logic       gen_tick,
  input  logic       restart,
  input  logic       ext_rise,
  input  logic       ext_fall,
  output logic       tx_tick,
  output logic       rx_tick,
  output logic       clk_lvl
);
  localparam int DIV_W = $clog2(OVS);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_top;
  logic             e_rise;
  logic             e_fall;

  assign div_top = (mode == CLK_ASYNC_2X) ? DIV_W'(OVS / 2 - 1) : DIV_W'(OVS - 1);
  assign e_rise  = inv ? ext_fall : ext_rise;
  assign e_fall  = inv ? ext_rise : ext_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      tx_tick <= 1'b0;
      rx_tick <= 1'b0;
      clk_lvl <= 1'b0;
    end else begin
      tx_tick <= 1'b0;
      rx_tick <= 1'b0;
      case (clk_mode_e'(mode))
        CLK_SYNC_MST: begin
          if (gen_tick) begin
            clk_lvl <= ~clk_lvl;
            if (clk_lvl) tx_tick <= 1'b1;
            else         rx_tick <= 1'b1;
          end
        end
        CLK_SPI_MST: begin
          if (gen_tick) begin
            clk_lvl <= ~clk_lvl;
            if (clk_lvl) rx_tick <= 1'b1;
            else         tx_tick <= 1'b1;
          end
        end
        CLK_SYNC_SLV: begin
          clk_lvl <= 1'b0;
          rx_tick <= e_rise;
          tx_tick <= e_fall;
        end
        default: begin
          clk_lvl <= 1'b0;
          if (restart) begin
            div_q <= '0;
          end else if (gen_tick) begin
            rx_tick <= 1'b1;
            if (div_q >= div_top) begin
              tx_tick <= 1'b1;
              div_q   <= '0;
            end else begin
              div_q <= div_q + DIV_W'(1);
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
`timescale 1ns/1ps
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int PER_W       = 12,
  parameter int SCL_W       = 4,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] per_val,
  input  logic [SCL_W-1:0] scale_val,
  input  logic [2:0]       mode,
  input  logic             xck_inv,
  input  logic             xck_in,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic             xck_out,
  output logic             xck_oe
);
  logic gen_tick;
  logic restart;
  logic ext_rise;
  logic ext_fall;
  logic clk_lvl;

  baud_period_gen #(.PER_W(PER_W), .SCL_W(SCL_W)) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .per      (per_val),
    .scale    (scale_val),
    .gen_tick (gen_tick),
    .restart  (restart)
  );

  xck_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (xck_in),
    .rise  (ext_rise),
    .fall  (ext_fall)
  );

  tick_router #(.OVS(OVS)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .inv      (xck_inv),
    .gen_tick (gen_tick),
    .restart  (restart),
    .ext_rise (ext_rise),
    .ext_fall (ext_fall),
    .tx_tick  (tx_tick),
    .rx_tick  (rx_tick),
    .clk_lvl  (clk_lvl)
  );

  assign xck_oe  = (mode == CLK_SYNC_MST) || (mode == CLK_SPI_MST);
  assign xck_out = clk_lvl ^ xck_inv;
endmodule

// File: rtl/frac_baud_chk.sv
`timescale 1ns/1ps
module frac_baud_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       xck_inv,
  input logic       tx_tick,
  input logic       rx_tick,
  input logic       xck_out,
  input logic       xck_oe,
  input logic       restart
);
  logic is_master;
  logic is_slave;
  logic is_async;

  assign is_master = (mode == 3'd2) || (mode == 3'd4);
  assign is_slave  = (mode == 3'd3);
  assign is_async  = !is_master && !is_slave;

  assert_restart_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && is_async) |=> !rx_tick);

  assert_tx_with_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick && $past(is_async)) |-> rx_tick);

  assert_released_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!xck_oe && $past(!xck_oe)) |-> (xck_out == xck_inv));

  assert_pin_edge_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(is_master) && $stable(xck_inv)) |-> ((xck_out != $past(xck_out)) == (tx_tick || rx_tick)));

  // Applies to R8 and R9: one kind of tick per cycle in clocked modes.
  assert_one_tick_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_master || is_slave) |-> $onehot0({tx_tick, rx_tick}));
endmodule

bind frac_baud_gen frac_baud_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (mode),
  .xck_inv (xck_inv),
  .tx_tick (tx_tick),
  .rx_tick (rx_tick),
  .xck_out (xck_out),
  .xck_oe  (xck_oe),
  .restart (restart)
);

// File: tb/frac_baud_gen_test.sv
`timescale 1ns/1ps
module frac_baud_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] per_val;
  logic [3:0]  scale_val;
  logic [2:0]  mode;
  logic        xck_inv;
  logic        xck_in;
  logic        tx_tick;
  logic        rx_tick;
  logic        xck_out;
  logic        xck_oe;
  int          errors = 0;
  int          checks = 0;

  always #5 clk = ~clk;

  frac_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .per_val(per_val), .scale_val(scale_val),
    .mode(mode), .xck_inv(xck_inv), .xck_in(xck_in),
    .tx_tick(tx_tick), .rx_tick(rx_tick), .xck_out(xck_out), .xck_oe(xck_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int p, input int s);
    @(negedge clk);
    per_val   = p[11:0];
    scale_val = s[3:0];
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Length in cycles of generator period number idx after a restart.
  function automatic int gen_period(input int p, input int s, input int idx);
    int k, whole, fr, acc, ex, sum;
    if (s >= 0) return (p + 1) << s;
    k = -s;
    whole = p >> k;
    fr = p & ((1 << k) - 1);
    acc = 0;
    ex = 0;
    for (int i = 0; i < idx; i++) begin
      sum = acc + fr;
      ex  = sum >> k;
      acc = sum & ((1 << k) - 1);
    end
    return whole + 1 + ex;
  endfunction

  task automatic sweep_one(input int p, input int s, input int nticks, input string req);
    int n, got, exp;
    cfg(p, s);
    n = 0;
    got = 0;
    while (got < nticks) begin
      step();
      n++;
      if (rx_tick) begin
        exp = gen_period(p, s, got) + ((got == 0) ? 1 : 0);
        check(n == exp, (got == 0) ? "R4" : req, n, exp);
        got++;
        n = 0;
      end
    end
  endtask

  task automatic tx_test(input int m, input int ovs);
    int rxc;
    @(negedge clk);
    mode = m[2:0];
    cfg(9, 0);
    cfg(1, 0);
    rxc = 0;
    while (rxc < 3 * ovs) begin
      step();
      if (rx_tick) begin
        rxc++;
        check(tx_tick == ((rxc % ovs) == 0), "R5", int'(tx_tick), int'((rxc % ovs) == 0));
      end else if (tx_tick) begin
        check(1'b0, "R5 tx without rx", 1, 0);
      end
    end
  endtask

  task automatic master_test(input int m, input bit inv, input string req);
    logic prev, cur;
    bit   e_rose, exp_rx;
    int   last;
    @(negedge clk);
    mode = m[2:0];
    xck_inv = inv;
    cfg(5, 0);
    cfg(2, 0);
    repeat (4) step();
    check(xck_oe == 1'b1, "R6", int'(xck_oe), 1);
    prev = xck_out;
    last = -1;
    for (int i = 1; i <= 60; i++) begin
      step();
      cur = xck_out;
      if (cur != prev) begin
        e_rose = cur ^ inv;
        exp_rx = (m == 2) ? e_rose : !e_rose;
        check(rx_tick == exp_rx, req, int'(rx_tick), int'(exp_rx));
        check(tx_tick == !exp_rx, req, int'(tx_tick), int'(!exp_rx));
        if (last >= 0) check((i - last) == 3, req, i - last, 3);
        last = i;
      end else begin
        check(!rx_tick && !tx_tick, req, int'({tx_tick, rx_tick}), 0);
      end
      prev = cur;
    end
    check(last > 0, req, last, 1);
  endtask

  task automatic slave_test(input bit inv);
    bit e_rose, hit;
    @(negedge clk);
    mode = 3'd3;
    xck_inv = inv;
    xck_in = 1'b0;
    repeat (5) step();
    check(xck_oe == 1'b0, "R6", int'(xck_oe), 0);
    check(xck_out == inv, "R6", int'(xck_out), int'(inv));
    for (int t = 0; t < 6; t++) begin
      xck_in = ~xck_in;
      e_rose = xck_in ^ inv;
      for (int j = 1; j <= 5; j++) begin
        step();
        hit = (j == 3);
        check(rx_tick == (hit && e_rose), "R9", int'(rx_tick), int'(hit && e_rose));
        check(tx_tick == (hit && !e_rose), "R9", int'(tx_tick), int'(hit && !e_rose));
      end
    end
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    per_val = 12'd7;
    scale_val = 4'd0;
    mode = 3'd0;
    xck_inv = 1'b0;
    xck_in = 1'b0;
    repeat (3) @(negedge clk);
    check(!tx_tick && !rx_tick, "R1", int'({tx_tick, rx_tick}), 0);
    check(xck_out == 1'b0, "R1", int'(xck_out), 0);
    rst_n = 1'b1;
    step();
    check(!tx_tick && !rx_tick, "R1", int'({tx_tick, rx_tick}), 0);
    check(xck_oe == 1'b0, "R6", int'(xck_oe), 0);

    // R2 and R3 grid sweep in mode 0, back-to-back reconfiguration (R4).
    for (int s = -3; s <= 3; s++) begin
      for (int p = 0; p < 16; p++) begin
        sweep_one(p, s, 6, (s < 0) ? "R3" : "R2");
      end
    end

    // Range limits.
    sweep_one(0, 0, 4, "R10");
    sweep_one(4095, 0, 3, "R10");
    sweep_one(3, 7, 3, "R2");
    sweep_one(200, -7, 10, "R3");
    sweep_one(4095, -7, 10, "R3");
    sweep_one(77, -5, 12, "R3");

    // Released pin rests at the polarity setting.
    @(negedge clk);
    xck_inv = 1'b1;
    step();
    check(xck_out == 1'b1 && xck_oe == 1'b0, "R6", int'(xck_out), 1);
    @(negedge clk);
    xck_inv = 1'b0;

    tx_test(0, 16);
    tx_test(1, 8);
    tx_test(6, 16);

    master_test(2, 1'b0, "R7");
    master_test(2, 1'b1, "R7");
    master_test(4, 1'b0, "R8");
    master_test(4, 1'b1, "R8");

    slave_test(1'b0);
    slave_test(1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule